// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Reload

This block is a general-purpose up-counter driven by a prescaled clock enable. While it runs, the counter advances by one on each enabled tick. When it reaches the active reload value, it returns to zero on the next tick and raises a one-cycle update pulse. The reload value either takes effect as soon as it is written, or waits in a shadow register until the next update, depending on a preload control bit. Software reaches the control, status, event, counter, reload and debug-configuration registers through a small memory-mapped bus. Writes must be 16 or 32 bits wide; reads may be any width.

A finite-state machine sets the counter's activity. It has three states:

- `ST_IDLE`: stopped.
- `ST_RUN`: counting.
- `ST_FROZEN`: halted for debug.

Its transitions are:

- `start`: IDLE to RUN, when the enable bit is written to 1.
- `stop`: RUN or FROZEN to IDLE, when the enable bit is written to 0.
- `pulse_end`: RUN to IDLE, on an overflow update in one-pulse mode.
- `freeze`: RUN to FROZEN, when the debug halt is high and the freeze configuration bit is set.
- `thaw`: FROZEN to RUN, when that condition drops.

The enable bit reads as 1 in both RUN and FROZEN.

Register map, at byte offsets:

| Offset | Register | Contents |
|---|---|---|
| 0x00 | control | see R2 |
| 0x04 | status | bit 0 is the update flag |
| 0x08 | event generation | bit 0 requests a software update |
| 0x0C | counter | counter value |
| 0x10 | reload | the shadow value |
| 0x14 | debug configuration | bit 0 enables freeze |

Top module: `upcount_timer`

## Requirements
- R1: After reset, the control, status and counter registers read 0, the reload register reads 0xFFFF and `upd_evt` is low.
- R2: Control bit 0 is enable, bit 1 is update disable, bit 2 is update source select, bit 3 is one-pulse and bit 7 is preload enable. Bits 6:4 and 31:8 read as 0.
- R3: In RUN, each tick increments the counter. A tick that finds the counter equal to the active reload value sets it to 0 and makes `upd_evt` high for the following cycle.
- R4: With preload enable at 0, a reload write changes the wrap point at once, even while counting.
- R5: With preload enable at 1, a reload write only updates the shadow value. The shadow moves to the active reload at the next update.
- R6: With one-pulse set, an overflow update clears the enable bit. The counter then stays at 0.
- R7: With one-pulse clear, the counter keeps wrapping and raising updates period after period.
- R8: When `dbg_halt` is high and debug configuration bit 0 is 1, ticks do not change the counter. With that bit at 0, `dbg_halt` has no effect.
- R9: With update disable set, the counter still wraps. No update pulse occurs, the flag is not set and the shadow value is not transferred.
- R10: Every update sets status bit 0, which stays set until software writes 0 to it. Writing 1 to it leaves it set.
- R11: Writing 1 to event generation bit 0 clears the counter, loads the shadow value and pulses `upd_evt`. It sets the flag only when update source select is 0.
- R12: A write with `bus_size` 0 (byte) changes no register. Reads return the full register for every size. Size code 1 means 16 bits and 2 means 32 bits.
- R13: A write to the counter register sets the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaled count enable |
| dbg_halt | input | 1 | Debug halt request |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| upd_evt | output | 1 | One-cycle update event pulse |

## Verification
The bench covers several kinds of internal fault:

- A wrong reload or counter value shifts the cycle in which `upd_evt` rises. The sweep samples the pulse after every single tick, so such a fault shows within one counting period.
- A faulty state register shows in the enable bit read back from control. It also shows as a counter that moves, or fails to move, on the very next tick.
- A shadow value that is lost or transferred at the wrong time changes the wrap point of the period after the update, so it shows one period late.
- A flag fault shows at the next status read.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } tstate_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [2:0] IDX_CTRL  = 3'd0;
    localparam logic [2:0] IDX_STAT  = 3'd1;
    localparam logic [2:0] IDX_EVGEN = 3'd2;
    localparam logic [2:0] IDX_COUNT = 3'd3;
    localparam logic [2:0] IDX_RELD  = 3'd4;
    localparam logic [2:0] IDX_DBG   = 3'd5;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [4:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             enabled,
    input  logic             flag_q,
    output logic             udis,
    output logic             urs,
    output logic             opm,
    output logic             arpe,
    output logic             dbg_stop,
    output logic [CNT_W-1:0] shadow_q,
    output logic             cen_set,
    output logic             cen_clr,
    output logic             arr_wr,
    output logic             cnt_wr,
    output logic             ug,
    output logic             flag_clr
);
    localparam int PAD = 32 - CNT_W;

    logic       wr_ok;
    logic [2:0] idx;

    assign idx   = bus_addr[4:2];
    assign wr_ok = bus_sel && bus_wr && (bus_size != SZ_BYTE);

    assign cen_set  = wr_ok && (idx == IDX_CTRL) && bus_wdata[0];
    assign cen_clr  = wr_ok && (idx == IDX_CTRL) && !bus_wdata[0];
    assign arr_wr   = wr_ok && (idx == IDX_RELD);
    assign cnt_wr   = wr_ok && (idx == IDX_COUNT);
    assign ug       = wr_ok && (idx == IDX_EVGEN) && bus_wdata[0];
    assign flag_clr = wr_ok && (idx == IDX_STAT) && !bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            udis     <= 1'b0;
            urs      <= 1'b0;
            opm      <= 1'b0;
            arpe     <= 1'b0;
            dbg_stop <= 1'b0;
            shadow_q <= RST_RELOAD;
        end else if (wr_ok) begin
            unique case (idx)
                IDX_CTRL: begin
                    udis <= bus_wdata[1];
                    urs  <= bus_wdata[2];
                    opm  <= bus_wdata[3];
                    arpe <= bus_wdata[7];
                end
                IDX_RELD: shadow_q <= bus_wdata[CNT_W-1:0];
                IDX_DBG:  dbg_stop <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_CTRL:  bus_rdata = {24'd0, arpe, 3'b000, opm, urs, udis, enabled};
            IDX_STAT:  bus_rdata = {31'd0, flag_q};
            IDX_COUNT: bus_rdata = {{PAD{1'b0}}, cnt_q};
            IDX_RELD:  bus_rdata = {{PAD{1'b0}}, shadow_q};
            IDX_DBG:   bus_rdata = {31'd0, dbg_stop};
            default:   bus_rdata = '0;
        endcase
    end

    // R12: a byte write leaves every software-held field unchanged
    a_r12_byte_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_size == SZ_BYTE)
        |=> $stable({udis, urs, opm, arpe, dbg_stop, shadow_q}));
endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             freeze,
    input  logic             cen_set,
    input  logic             cen_clr,
    input  logic             udis,
    input  logic             urs,
    input  logic             opm,
    input  logic             arpe,
    input  logic             arr_wr,
    input  logic             cnt_wr,
    input  logic             ug,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] shadow_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             enabled,
    output logic             flag_q,
    output logic             upd_evt
);
    tstate_e          state_q, state_d;
    logic [CNT_W-1:0] arr_q;
    logic             count_en, ovf, ovf_upd, upd_now;

    assign count_en = (state_q == ST_RUN) && !freeze && tick_en;
    assign ovf      = count_en && (cnt_q == arr_q);
    assign ovf_upd  = ovf && !udis;
    assign upd_now  = ovf_upd || ug;
    assign enabled  = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cen_set) state_d = ST_RUN;
            ST_RUN: begin
                if (cen_clr || (ovf_upd && opm)) state_d = ST_IDLE;
                else if (freeze)                 state_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (cen_clr)      state_d = ST_IDLE;
                else if (!freeze) state_d = ST_RUN;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            arr_q   <= RST_RELOAD;
            flag_q  <= 1'b0;
            upd_evt <= 1'b0;
        end else begin
            upd_evt <= upd_now;
            if (ug)            cnt_q <= '0;
            else if (cnt_wr)   cnt_q <= wdata;
            else if (ovf)      cnt_q <= '0;
            else if (count_en) cnt_q <= cnt_q + 1'b1;

            if (arr_wr && !arpe) arr_q <= wdata;
            else if (upd_now)    arr_q <= shadow_q;

            if (ovf_upd || (ug && !urs)) flag_q <= 1'b1;
            else if (flag_clr)           flag_q <= 1'b0;
        end
    end

    // R3: an overflow not overridden by software leaves the counter at zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cnt_wr && !ug) |=> (cnt_q == '0));
    // R6: an overflow update in one-pulse mode ends in IDLE
    a_r6_opm_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_upd && opm) |=> (state_q == ST_IDLE));
    // R8: a frozen counter holds its value unless software writes it
    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && !cnt_wr && !ug) |=> $stable(cnt_q));
    // R9: update disable suppresses the pulse on an overflow
    a_r9_udis_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && udis && !ug) |=> !upd_evt);
    // R10: the flag stays set until cleared by software
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        dbg_halt,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        upd_evt
);
    logic [CNT_W-1:0] cnt_q, shadow_q;
    logic enabled, flag_q, udis, urs, opm, arpe, dbg_stop;
    logic cen_set, cen_clr, arr_wr, cnt_wr, ug, flag_clr;

    timer_regs #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_q(cnt_q), .enabled(enabled), .flag_q(flag_q),
        .udis(udis), .urs(urs), .opm(opm), .arpe(arpe), .dbg_stop(dbg_stop),
        .shadow_q(shadow_q), .cen_set(cen_set), .cen_clr(cen_clr),
        .arr_wr(arr_wr), .cnt_wr(cnt_wr), .ug(ug), .flag_clr(flag_clr)
    );

    timer_core #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .freeze(dbg_halt && dbg_stop),
        .cen_set(cen_set), .cen_clr(cen_clr),
        .udis(udis), .urs(urs), .opm(opm), .arpe(arpe),
        .arr_wr(arr_wr), .cnt_wr(cnt_wr), .ug(ug), .flag_clr(flag_clr),
        .wdata(bus_wdata[CNT_W-1:0]), .shadow_q(shadow_q),
        .cnt_q(cnt_q), .enabled(enabled), .flag_q(flag_q), .upd_evt(upd_evt)
    );
endmodule

// File: tb/upcount_timer_test.sv
`timescale 1ns/1ps
module upcount_timer_test;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_EVG = 5'h08,
                           A_CNT = 5'h0C, A_RELD = 5'h10, A_DBG = 5'h14;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, dbg_halt = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [1:0] bus_size = 2'd2;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic upd_evt;
    int checks = 0, errors = 0;
    logic [31:0] rv;
    bit done = 0;

    always #5 clk = ~clk;

    upcount_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_evt(upd_evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [1:0] sz, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 upd", {31'd0, upd_evt}, 0);
        rd(A_CTRL, 2, rv); check("R1 ctrl", rv, 0);
        rd(A_STAT, 2, rv); check("R1 stat", rv, 0);
        rd(A_CNT, 2, rv);  check("R1 cnt", rv, 0);
        rd(A_RELD, 2, rv); check("R1 reload", rv, 32'hFFFF);
        // R2 bit layout, reserved bits read zero
        wr(A_CTRL, 32'hFFFF_FF8E, 1);
        rd(A_CTRL, 2, rv); check("R2 ctrl layout", rv, 32'h8E);
        wr(A_CTRL, 0, 2);
        // R12 byte writes ignored, reads of any size full
        wr(A_CTRL, 32'h81, 0);
        rd(A_CTRL, 2, rv); check("R12 byte ctrl", rv, 0);
        wr(A_RELD, 32'h12, 0);
        rd(A_RELD, 0, rv); check("R12 byte reload", rv, 32'hFFFF);
        wr(A_RELD, 32'h1234, 1);
        rd(A_RELD, 0, rv); check("R12 half reload", rv, 32'h1234);
        // R13 counter write
        wr(A_CNT, 32'h4, 2);
        rd(A_CNT, 1, rv); check("R13 cnt write", rv, 4);
        // R3 / R4 / R7 sweep over reload values, two periods each
        for (int a = 0; a <= 5; a++) begin
            wr(A_RELD, a, 2);
            wr(A_CNT, 0, 2);
            wr(A_CTRL, 1, 2);
            for (int k = 1; k <= 2 * (a + 1); k++) begin
                tick();
                check("R3 R7 upd", {31'd0, upd_evt}, ((k % (a + 1)) == 0) ? 1 : 0);
                rd(A_CNT, 2, rv); check("R3 cnt", rv, k % (a + 1));
            end
            wr(A_CTRL, 0, 2);
        end
        // R10 sticky flag
        rd(A_STAT, 2, rv); check("R10 flag set", rv, 1);
        wr(A_STAT, 1, 2);
        rd(A_STAT, 2, rv); check("R10 write one keeps", rv, 1);
        wr(A_STAT, 0, 2);
        rd(A_STAT, 2, rv); check("R10 write zero clears", rv, 0);
        // R4 immediate reload change while running
        wr(A_RELD, 5, 2); wr(A_CNT, 0, 2); wr(A_CTRL, 1, 2);
        ticks(2);
        wr(A_RELD, 3, 2);
        tick(); check("R4 no early upd", {31'd0, upd_evt}, 0);
        rd(A_CNT, 2, rv); check("R4 cnt", rv, 3);
        tick(); check("R4 upd at new reload", {31'd0, upd_evt}, 1);
        rd(A_CNT, 2, rv); check("R4 wrapped", rv, 0);
        // R5 buffered reload
        wr(A_CTRL, 32'h81, 2);
        wr(A_RELD, 6, 2);
        rd(A_RELD, 2, rv); check("R5 shadow read", rv, 6);
        ticks(3); rd(A_CNT, 2, rv); check("R5 old reload holds", rv, 3);
        tick(); check("R5 upd at old reload", {31'd0, upd_evt}, 1);
        ticks(6); check("R5 no upd before new", {31'd0, upd_evt}, 0);
        rd(A_CNT, 2, rv); check("R5 cnt", rv, 6);
        tick(); check("R5 upd at new reload", {31'd0, upd_evt}, 1);
        // R9 update disable
        wr(A_CTRL, 32'h83, 2);
        wr(A_STAT, 0, 2);
        wr(A_RELD, 2, 2);
        ticks(6); tick();
        check("R9 no pulse", {31'd0, upd_evt}, 0);
        rd(A_CNT, 2, rv); check("R9 wrapped", rv, 0);
        rd(A_STAT, 2, rv); check("R9 no flag", rv, 0);
        ticks(3); rd(A_CNT, 2, rv); check("R9 shadow not moved", rv, 3);
        // R11 software update
        wr(A_CTRL, 32'h80, 2);
        wr(A_EVG, 1, 2);
        check("R11 pulse", {31'd0, upd_evt}, 1);
        rd(A_CNT, 2, rv); check("R11 cnt cleared", rv, 0);
        rd(A_STAT, 2, rv); check("R11 flag", rv, 1);
        wr(A_CTRL, 32'h81, 2);
        ticks(2); check("R11 no early", {31'd0, upd_evt}, 0);
        tick(); check("R11 shadow loaded", {31'd0, upd_evt}, 1);
        wr(A_CTRL, 32'h85, 2);
        wr(A_STAT, 0, 2);
        wr(A_EVG, 1, 2);
        check("R11 urs pulse", {31'd0, upd_evt}, 1);
        rd(A_STAT, 2, rv); check("R11 urs no flag", rv, 0);
        // R6 one-pulse
        wr(A_CTRL, 0, 2); wr(A_RELD, 2, 2); wr(A_CNT, 0, 2);
        wr(A_CTRL, 32'h09, 2);
        ticks(2); tick();
        check("R6 upd", {31'd0, upd_evt}, 1);
        rd(A_CTRL, 2, rv); check("R6 enable cleared", rv, 32'h08);
        ticks(2); rd(A_CNT, 2, rv); check("R6 stays zero", rv, 0);
        // R8 debug freeze
        wr(A_DBG, 1, 2); wr(A_CTRL, 1, 2);
        dbg_halt = 1'b1; @(negedge clk);
        ticks(2); rd(A_CNT, 2, rv); check("R8 frozen", rv, 0);
        rd(A_CTRL, 2, rv); check("R8 enable reads 1", rv, 1);
        dbg_halt = 1'b0; @(negedge clk);
        tick(); rd(A_CNT, 2, rv); check("R8 resumed", rv, 1);
        wr(A_DBG, 0, 2);
        dbg_halt = 1'b1; @(negedge clk);
        tick(); rd(A_CNT, 2, rv); check("R8 halt ignored", rv, 2);
        dbg_halt = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule